// File: doc/BRIEF.md
# Extended Idle State Entry Sequencer

This block sits between the idle-request logic of a processor package and two external agents: the voltage/frequency engine that moves the package between operating points, and the clock-gating controller that consumes the idle state it reports. A plain idle request puts the package straight into the requested idle depth. An extended request first lowers the package to its lowest operating point and enters the idle depth only after that. On a break event it hands the core back to software at once, while the return to the saved point runs in the background.

A request is extended when the requester sets a hint bit, or when a configuration bit promotes every request. In both cases the requested depth must be one that supports an extended form. A second configuration bit enables a special mode for the deepest state. In that mode the core voltage is lowered in place while the package sleeps. On wake-up the package goes to the lowest point, not back to the saved one. Operating-point transitions are issued only in the down and up phases, never while the package reports an idle depth. This keeps them out of the clock-stopped states.

Top module: `xidle_seq`

## Requirements
- R1: An idle request with a valid depth (1 to 4) that is not extended sets `cstate` to that depth and `core_run` to 0 on the next cycle, with no transition request.
- R2: An extended request raises `vf_req` on the next cycle with `vf_target` = `low_point` and `core_run` = 0. `cstate` becomes the depth only in the cycle after `vf_ack`.
- R3: A request is extended when `idle_ext_hint` or `cfg_promote` is 1 and the depth supports it (1 to 4). Requests for depth 0 or depths 5 to 7 are ignored.
- R4: A break event in an extended idle state sets `core_run` = 1 and `cstate` = 0 on the next cycle. In the same cycle it raises `vf_req` with `vf_target` equal to the `op_point` latched at entry. `vf_req` falls in the cycle after `vf_ack`.
- R5: A break event in a non-extended idle state returns to running on the next cycle, with `cstate` = 0 and no transition request.
- R6: A break event during the down transition, including one in the same cycle as `vf_ack`, aborts entry. `cstate` stays 0. After the acknowledgement the block goes straight to the up transition toward the saved point, with `core_run` = 1.
- R7: When `cfg_hard_deep` is 1 and depth 4 is entered extended, `deep_volt` is 1 while idle and the exit target is `low_point`. At other depths `deep_volt` stays 0 and the exit target is the saved point.
- R8: A valid idle request made while an up transition is pending is held. In the cycle after `vf_ack` the held request is started, and for an extended request the saved point is the up target just reached.
- R9: `vf_req` stays high with a stable `vf_target` until `vf_ack`. It is never high while `cstate` is non-zero.
- R10: Idle requests arriving during the down transition or while idle are ignored. Break events arriving while running are ignored.
- R11: During reset `core_run` = 1, `cstate` = 0, `vf_req` = 0 and `deep_volt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | One-cycle idle request pulse |
| idle_depth | input | 3 | Requested idle depth (1..4 valid) |
| idle_ext_hint | input | 1 | Requests the extended form of this entry |
| cfg_promote | input | 1 | Promotes every request to the extended form |
| cfg_hard_deep | input | 1 | Enables in-place voltage lowering for depth 4 |
| break_evt | input | 1 | Wake-up event pulse |
| op_point | input | PT_W | Current operating point |
| low_point | input | PT_W | Lowest operating point |
| vf_ack | input | 1 | Engine completion pulse |
| vf_req | output | 1 | Transition request, held until acknowledged |
| vf_target | output | PT_W | Target point of the pending transition |
| core_run | output | 1 | Core is released to software |
| cstate | output | 3 | Idle depth reported to clock gating, 0 when running |
| deep_volt | output | 1 | Voltage lowered in place for the deepest state |

## Verification
Two pairs of events can coincide. A break can land in the same cycle as the engine's acknowledgement of the down transition. A new idle request can arrive while an up transition is still awaiting its acknowledgement. The bench drives both pairs, once on the same edge and once split across cycles. It predicts the outputs for each cycle: entry must never be reported when a break came first, and the held request must start only in the cycle after the acknowledgement, with the up target as its saved point.

// File: rtl/xidle_pkg.sv
// Shared types for the extended idle sequencer.
// Assumes: depth field is three bits; state encoding is internal only.
package xidle_pkg;
    localparam int DEPTH_W = 3;
    localparam int DEPTH_N = 1 << DEPTH_W;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_DOWN = 2'd1,
        S_IDLE = 2'd2,
        S_UP   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/xidle_decode.sv
// Classifies an idle request: valid depth, extended form, hard-deep form.
// Assumes: masks are indexed by depth; deepest depth lies inside the masks.
module xidle_decode #(
    parameter int                              DEEPEST    = 4,
    parameter logic [xidle_pkg::DEPTH_N-1:0]   VALID_MASK = 8'b0001_1110,
    parameter logic [xidle_pkg::DEPTH_N-1:0]   EXT_MASK   = 8'b0001_1110
) (
    input  logic [xidle_pkg::DEPTH_W-1:0] depth,
    input  logic                          hint,
    input  logic                          promote,
    input  logic                          hard_en,
    output logic                          valid,
    output logic                          ext,
    output logic                          hard
);
    localparam int DN = xidle_pkg::DEPTH_N;

    logic [DN-1:0] depth_hot;

    // One-hot view of the depth so each mask bit is tested by its own gate.
    genvar gi;
    generate
        for (gi = 0; gi < DN; gi++) begin : g_hot
            assign depth_hot[gi] = (depth == xidle_pkg::DEPTH_W'(gi));
        end
    endgenerate

    // Decode request class from the masks and configuration bits.
    always_comb begin
        valid = |(depth_hot & VALID_MASK);
        ext   = valid && (|(depth_hot & EXT_MASK)) && (hint || promote);
        hard  = ext && hard_en && (depth == xidle_pkg::DEPTH_W'(DEEPEST));
    end
endmodule

// File: rtl/xidle_pend.sv
// Holds one idle request that arrived while an up transition was pending.
// Assumes: only the first request is kept; the slot clears on engine ack.
module xidle_pend #(
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_busy,
    input  logic               vf_ack,
    input  logic               new_v,
    input  logic [DEPTH_W-1:0] new_depth,
    input  logic               new_ext,
    input  logic               new_hard,
    output logic               pend_v,
    output logic [DEPTH_W-1:0] pend_depth,
    output logic               pend_ext,
    output logic               pend_hard
);
    logic capture;
    logic clear;

    // Capture only when the slot is free and no ack closes the phase now.
    always_comb begin
        capture = up_busy && !vf_ack && new_v && !pend_v;
        clear   = up_busy && vf_ack;
    end

    // Storage for the held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_depth <= '0;
            pend_ext   <= 1'b0;
            pend_hard  <= 1'b0;
        end else if (clear) begin
            pend_v <= 1'b0;
        end else if (capture) begin
            pend_v     <= 1'b1;
            pend_depth <= new_depth;
            pend_ext   <= new_ext;
            pend_hard  <= new_hard;
        end
    end

    a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
        (up_busy && !vf_ack && new_v) |=> pend_v);

    a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !(up_busy && vf_ack)) |=> (pend_v && $stable(pend_depth)));
endmodule

// File: rtl/xidle_fsm.sv
// Sequencer core: run, down transition, idle, background up transition.
// Assumes: vf_ack is a one-cycle pulse ending the request that is high;
// a new request may start in the cycle after an ack.
module xidle_fsm #(
    parameter int PT_W    = 4,
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               new_v,
    input  logic [DEPTH_W-1:0] new_depth,
    input  logic               new_ext,
    input  logic               new_hard,
    input  logic               pend_v,
    input  logic [DEPTH_W-1:0] pend_depth,
    input  logic               pend_ext,
    input  logic               pend_hard,
    input  logic               break_evt,
    input  logic               vf_ack,
    input  logic [PT_W-1:0]    op_point,
    input  logic [PT_W-1:0]    low_point,
    output logic               up_busy,
    output logic               core_run_o,
    output logic [DEPTH_W-1:0] cstate_o,
    output logic               vf_req_o,
    output logic [PT_W-1:0]    vf_target_o,
    output logic               deep_volt_o
);
    import xidle_pkg::*;

    seq_state_e         state_q;
    logic [DEPTH_W-1:0] depth_q;
    logic               ext_q;
    logic               hard_q;
    logic               abort_q;
    logic [PT_W-1:0]    saved_q;
    logic [PT_W-1:0]    target_q;

    logic               in_up;
    logic               use_pend;
    logic               sel_v;
    logic [DEPTH_W-1:0] sel_depth;
    logic               sel_ext;
    logic               sel_hard;
    logic               accept;
    logic [PT_W-1:0]    entry_pt;

    // Choose the request to start: a held one wins over a fresh one.
    always_comb begin
        in_up     = (state_q == S_UP);
        use_pend  = in_up && pend_v;
        sel_v     = use_pend ? 1'b1       : new_v;
        sel_depth = use_pend ? pend_depth : new_depth;
        sel_ext   = use_pend ? pend_ext   : new_ext;
        sel_hard  = use_pend ? pend_hard  : new_hard;
        accept    = ((state_q == S_RUN) && new_v) || (in_up && vf_ack && sel_v);
        entry_pt  = in_up ? target_q : op_point;
    end

    // State, latched request and transition targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_RUN;
            depth_q  <= '0;
            ext_q    <= 1'b0;
            hard_q   <= 1'b0;
            abort_q  <= 1'b0;
            saved_q  <= '0;
            target_q <= '0;
        end else if (accept) begin
            depth_q <= sel_depth;
            ext_q   <= sel_ext;
            hard_q  <= sel_hard;
            abort_q <= 1'b0;
            if (sel_ext) begin
                state_q  <= S_DOWN;
                saved_q  <= entry_pt;
                target_q <= low_point;
            end else begin
                state_q <= S_IDLE;
            end
        end else begin
            case (state_q)
                S_DOWN: begin
                    if (vf_ack) begin
                        if (abort_q || break_evt) begin
                            state_q  <= S_UP;
                            target_q <= saved_q;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end else if (break_evt) begin
                        abort_q <= 1'b1;
                    end
                end
                S_IDLE: begin
                    if (break_evt) begin
                        if (ext_q) begin
                            state_q  <= S_UP;
                            target_q <= hard_q ? low_point : saved_q;
                        end else begin
                            state_q <= S_RUN;
                        end
                    end
                end
                S_UP: begin
                    if (vf_ack) state_q <= S_RUN;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Moore outputs derived from the state.
    always_comb begin
        up_busy     = in_up;
        core_run_o  = (state_q == S_RUN) || in_up;
        cstate_o    = (state_q == S_IDLE) ? depth_q : '0;
        vf_req_o    = (state_q == S_DOWN) || in_up;
        vf_target_o = target_q;
        deep_volt_o = (state_q == S_IDLE) && hard_q;
    end

    a_r2_down_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) != S_IDLE && ext_q) |-> $past(vf_ack));

    a_r4_wake_now: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && ext_q && break_evt) |=> (core_run_o && vf_req_o));

    a_r7_hard_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && hard_q && break_evt) |=> (vf_target_o == $past(low_point)));

    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_req_o && !vf_ack) |=> (vf_req_o && $stable(vf_target_o)));

    a_r9_no_vf_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate_o != '0) |-> !vf_req_o);

    a_r10_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !break_evt) |=> (state_q == S_IDLE));
endmodule

// File: rtl/xidle_seq.sv
// Top: extended idle entry/exit sequencer with engine and clock-gate ports.
// Assumes: idle_req and break_evt are pulses; op_point is valid at request.
module xidle_seq #(
    parameter int                            PT_W       = 4,
    parameter int                            DEEPEST    = 4,
    parameter logic [xidle_pkg::DEPTH_N-1:0] VALID_MASK = 8'b0001_1110,
    parameter logic [xidle_pkg::DEPTH_N-1:0] EXT_MASK   = 8'b0001_1110
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          idle_req,
    input  logic [xidle_pkg::DEPTH_W-1:0] idle_depth,
    input  logic                          idle_ext_hint,
    input  logic                          cfg_promote,
    input  logic                          cfg_hard_deep,
    input  logic                          break_evt,
    input  logic [PT_W-1:0]               op_point,
    input  logic [PT_W-1:0]               low_point,
    input  logic                          vf_ack,
    output logic                          vf_req,
    output logic [PT_W-1:0]               vf_target,
    output logic                          core_run,
    output logic [xidle_pkg::DEPTH_W-1:0] cstate,
    output logic                          deep_volt
);
    localparam int DW = xidle_pkg::DEPTH_W;

    logic          dec_valid, dec_ext, dec_hard;
    logic          new_v;
    logic          up_busy;
    logic          pend_v, pend_ext, pend_hard;
    logic [DW-1:0] pend_depth;

    xidle_decode #(
        .DEEPEST(DEEPEST), .VALID_MASK(VALID_MASK), .EXT_MASK(EXT_MASK)
    ) u_dec (
        .depth(idle_depth), .hint(idle_ext_hint), .promote(cfg_promote),
        .hard_en(cfg_hard_deep), .valid(dec_valid), .ext(dec_ext), .hard(dec_hard)
    );

    // A request counts only when strobed with a valid depth.
    always_comb new_v = idle_req && dec_valid;

    xidle_pend #(.DEPTH_W(DW)) u_pend (
        .clk(clk), .rst_n(rst_n), .up_busy(up_busy), .vf_ack(vf_ack),
        .new_v(new_v), .new_depth(idle_depth), .new_ext(dec_ext), .new_hard(dec_hard),
        .pend_v(pend_v), .pend_depth(pend_depth), .pend_ext(pend_ext), .pend_hard(pend_hard)
    );

    xidle_fsm #(.PT_W(PT_W), .DEPTH_W(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .new_v(new_v), .new_depth(idle_depth), .new_ext(dec_ext), .new_hard(dec_hard),
        .pend_v(pend_v), .pend_depth(pend_depth), .pend_ext(pend_ext), .pend_hard(pend_hard),
        .break_evt(break_evt), .vf_ack(vf_ack), .op_point(op_point), .low_point(low_point),
        .up_busy(up_busy), .core_run_o(core_run), .cstate_o(cstate), .vf_req_o(vf_req),
        .vf_target_o(vf_target), .deep_volt_o(deep_volt)
    );

    a_r11_reset: assert property (@(posedge clk)
        (!rst_n) |=> (core_run && cstate == '0 && !vf_req && !deep_volt));
endmodule

// File: tb/tb_xidle_seq.sv
// Scoreboard bench: steps push expected outputs, a monitor compares them.
module tb_xidle_seq;
    localparam int PT_W = 4;

    typedef struct packed {
        logic       run;
        logic [2:0] cs;
        logic       vf;
        logic [3:0] tgt;
        logic       deep;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            idle_req = 1'b0;
    logic [2:0]      idle_depth = '0;
    logic            idle_ext_hint = 1'b0;
    logic            cfg_promote = 1'b0;
    logic            cfg_hard_deep = 1'b0;
    logic            break_evt = 1'b0;
    logic [PT_W-1:0] op_point = 4'd9;
    logic [PT_W-1:0] low_point = 4'd2;
    logic            vf_ack = 1'b0;
    logic            vf_req;
    logic [PT_W-1:0] vf_target;
    logic            core_run;
    logic [2:0]      cstate;
    logic            deep_volt;

    int    checks = 0;
    int    errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    xidle_seq #(.PT_W(PT_W)) dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_depth(idle_depth),
        .idle_ext_hint(idle_ext_hint), .cfg_promote(cfg_promote),
        .cfg_hard_deep(cfg_hard_deep), .break_evt(break_evt), .op_point(op_point),
        .low_point(low_point), .vf_ack(vf_ack), .vf_req(vf_req), .vf_target(vf_target),
        .core_run(core_run), .cstate(cstate), .deep_volt(deep_volt)
    );

    function automatic void compare(exp_t e, string tag);
        logic ok;
        ok = (core_run == e.run) && (cstate == e.cs) && (vf_req == e.vf) &&
             (deep_volt == e.deep) && (!e.vf || vf_target == e.tgt);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got run=%0d cs=%0d vf=%0d tgt=%0d deep=%0d exp run=%0d cs=%0d vf=%0d tgt=%0d deep=%0d",
                     tag, core_run, cstate, vf_req, vf_target, deep_volt,
                     e.run, e.cs, e.vf, e.tgt, e.deep);
        end
    endfunction

    // Monitor: after each rising edge, compare against the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    // Driver: one cycle of stimulus plus the outputs expected after the edge.
    task automatic step(input bit rq, input int d, input bit h, input bit b, input bit a,
                        input bit er, input int ec, input bit ev, input int et,
                        input bit ed, input string tag);
        exp_t e;
        @(negedge clk);
        idle_req      = rq;
        idle_depth    = 3'(d);
        idle_ext_hint = h;
        break_evt     = b;
        vf_ack        = a;
        e.run = er; e.cs = 3'(ec); e.vf = ev; e.tgt = 4'(et); e.deep = ed;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #1;
        r = '{run: 1'b1, cs: 3'd0, vf: 1'b0, tgt: 4'd0, deep: 1'b0};
        compare(r, "R11 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 plain entry, R5 plain exit
        step(1, 2, 0, 0, 0,  0, 2, 0, 0, 0, "R1 plain enter");
        step(0, 0, 0, 0, 0,  0, 2, 0, 0, 0, "R1 stays idle");
        step(0, 0, 0, 1, 0,  1, 0, 0, 0, 0, "R5 plain wake");
        step(0, 0, 0, 0, 0,  1, 0, 0, 0, 0, "R5 running");

        // R2 hint entry, R9 hold, R10 ignored request, R4 background exit
        step(1, 1, 1, 0, 0,  0, 0, 1, 2, 0, "R2 down first");
        step(0, 0, 0, 0, 0,  0, 0, 1, 2, 0, "R9 request held");
        step(0, 0, 0, 0, 1,  0, 1, 0, 0, 0, "R2 idle after ack");
        step(1, 3, 0, 0, 0,  0, 1, 0, 0, 0, "R10 request in idle ignored");
        step(0, 0, 0, 1, 0,  1, 0, 1, 9, 0, "R4 wake up transition");
        step(0, 0, 0, 0, 0,  1, 0, 1, 9, 0, "R9 up held");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R4 up done");

        // R3 promotion, clock-stopped depth 3
        cfg_promote = 1'b1;
        op_point = 4'd7;
        step(1, 3, 0, 0, 0,  0, 0, 1, 2, 0, "R3 promoted down");
        step(0, 0, 0, 0, 1,  0, 3, 0, 0, 0, "R9 no request in depth 3");
        step(0, 0, 0, 1, 0,  1, 0, 1, 7, 0, "R3 promoted wake");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R3 back running");
        cfg_promote = 1'b0;
        op_point = 4'd9;

        // R3 invalid depths, R10 break while running
        step(1, 0, 1, 0, 0,  1, 0, 0, 0, 0, "R3 depth 0 ignored");
        step(1, 5, 1, 0, 0,  1, 0, 0, 0, 0, "R3 depth 5 ignored");
        step(0, 0, 0, 1, 0,  1, 0, 0, 0, 0, "R10 break while running");

        // R6 break during down, split cycles
        step(1, 2, 1, 0, 0,  0, 0, 1, 2, 0, "R6 down start");
        step(0, 0, 0, 1, 0,  0, 0, 1, 2, 0, "R6 break held in down");
        step(1, 4, 0, 0, 0,  0, 0, 1, 2, 0, "R10 request in down ignored");
        step(0, 0, 0, 0, 1,  1, 0, 1, 9, 0, "R6 abort to up");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R6 up done");

        // R6 break on the same edge as the ack
        step(1, 2, 1, 0, 0,  0, 0, 1, 2, 0, "R6 down start same edge");
        step(0, 0, 0, 1, 1,  1, 0, 1, 9, 0, "R6 break with ack");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R6 up done same edge");

        // R7 hard deepest state
        cfg_hard_deep = 1'b1;
        step(1, 4, 1, 0, 0,  0, 0, 1, 2, 0, "R7 down for depth 4");
        step(0, 0, 0, 0, 1,  0, 4, 0, 0, 1, "R7 deep voltage");
        step(0, 0, 0, 0, 0,  0, 4, 0, 0, 1, "R7 deep voltage held");
        step(0, 0, 0, 1, 0,  1, 0, 1, 2, 0, "R7 exit to lowest");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R7 exit done");
        step(1, 2, 1, 0, 0,  0, 0, 1, 2, 0, "R7 depth 2 down");
        step(0, 0, 0, 0, 1,  0, 2, 0, 0, 0, "R7 no deep voltage at 2");
        step(0, 0, 0, 1, 0,  1, 0, 1, 9, 0, "R7 depth 2 exit saved");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R7 depth 2 done");
        cfg_hard_deep = 1'b0;

        // R8 extended request held during up
        step(1, 1, 1, 0, 0,  0, 0, 1, 2, 0, "R8 first down");
        step(0, 0, 0, 0, 1,  0, 1, 0, 0, 0, "R8 first idle");
        step(0, 0, 0, 1, 0,  1, 0, 1, 9, 0, "R8 up started");
        op_point = 4'd5;
        step(1, 2, 1, 0, 0,  1, 0, 1, 9, 0, "R8 request held in up");
        step(0, 0, 0, 0, 0,  1, 0, 1, 9, 0, "R8 still up");
        step(0, 0, 0, 0, 1,  0, 0, 1, 2, 0, "R8 held request starts");
        step(0, 0, 0, 0, 1,  0, 2, 0, 0, 0, "R8 held request idle");
        step(0, 0, 0, 1, 0,  1, 0, 1, 9, 0, "R8 saved is up target");
        step(0, 0, 0, 0, 1,  1, 0, 0, 0, 0, "R8 done");
        op_point = 4'd9;

        // R8 plain request held during up
        step(1, 1, 1, 0, 0,  0, 0, 1, 2, 0, "R8 second down");
        step(0, 0, 0, 0, 1,  0, 1, 0, 0, 0, "R8 second idle");
        step(0, 0, 0, 1, 0,  1, 0, 1, 9, 0, "R8 second up");
        step(1, 3, 0, 0, 0,  1, 0, 1, 9, 0, "R8 plain held");
        step(0, 0, 0, 0, 1,  0, 3, 0, 0, 0, "R8 plain enters after ack");
        step(0, 0, 0, 1, 0,  1, 0, 0, 0, 0, "R5 plain wake from 3");

        step(0, 0, 0, 0, 0,  1, 0, 0, 0, 0, "R10 idle bus");
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule